// File: doc/BRIEF.md
# Time-Triggered Matrix Cycle Tracker

This block tracks the position of a time-triggered CAN node inside its matrix cycle. A matrix cycle is a run of basic cycles. Each basic cycle opens with a reference window (window index 0) and continues through time windows 1 to n, each opened by a time mark. The block keeps a basic cycle count, a window index and a cycle time. It also keeps a flag that says whether the cycle time can be trusted.

Protocol events drive the counters, not free-running time. The controller supplies single-cycle strobes for leaving and entering configuration mode, for a correctly transferred reference message, for a failed reference message, for a time mark and for a local time tick. The limits m and n come in as inputs. A basic cycle is only recognised once its reference message has gone through correctly. Until then the cycle time is held and flagged invalid.

Top module: `ttmc_tracker`

## Requirements
- R1: After reset, all outputs are 0, time_valid is low, and the block is in configuration mode.
- R2: In configuration mode, ref_ok, ref_err, time_mark and time_tick have no effect on any output.
- R3: A cfg_exit strobe without cfg_enter leaves configuration mode. In the next cycle, cycle_count, window_idx and cycle_time are 0 and time_valid is low. This holds whatever the previous state was.
- R4: The first ref_ok after leaving configuration mode keeps cycle_count at 0 and sets time_valid high in the next cycle.
- R5: Each later ref_ok increments cycle_count by one. When cycle_count is already at max_cycle or above, it returns to 0 instead.
- R6: ref_ok sets window_idx and cycle_time to 0 in the next cycle. A time_mark or time_tick in the same cycle is overridden.
- R7: A time_mark while time_valid is high increments window_idx by one. When window_idx is already at max_window or above, the mark is ignored.
- R8: A time_mark or time_tick while time_valid is low leaves window_idx and cycle_time unchanged.
- R9: A time_tick while time_valid is high increments cycle_time by one, modulo 2^TIME_W.
- R10: A ref_err without ref_ok clears time_valid in the next cycle. The counters are kept.
- R11: cfg_enter returns the block to configuration mode and clears time_valid in the next cycle. It wins over a cfg_exit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_exit | input | 1 | Strobe: configuration mode left |
| cfg_enter | input | 1 | Strobe: configuration mode entered |
| ref_ok | input | 1 | Strobe: reference message transferred correctly |
| ref_err | input | 1 | Strobe: reference message transfer failed |
| time_mark | input | 1 | Strobe: time mark reached, opens the next time window |
| time_tick | input | 1 | Local time tick |
| max_cycle | input | CNT_W | Highest basic cycle count m |
| max_window | input | WIN_W | Highest window index n |
| cycle_count | output | CNT_W | Current basic cycle count |
| window_idx | output | WIN_W | Current window index, 0 for the reference window |
| cycle_time | output | TIME_W | Cycle time since the start of the basic cycle |
| time_valid | output | 1 | Cycle time is trusted |

## Verification
Each output comes from a single register. A wrong internal state therefore shows at the ports one cycle after the event that caused it.

Each kind of fault shows up in its own way:
- A stuck "first reference" flag gives an off-by-one cycle_count on the second reference message.
- A wrong validity gate shows as window_idx or cycle_time moving while time_valid is low.
- A bad wrap compare shows at the ref_ok that follows cycle_count reaching max_cycle.

Because the bench compares against its model on every clock, each of these is caught in the cycle it first appears.

// File: rtl/ttmc_pkg.sv
package ttmc_pkg;

  // Decoded, prioritised events shared by the counters
  typedef struct packed {
    logic restart;     // leave configuration mode
    logic ref_accept;  // correctly transferred reference message, while running
    logic first_ref;   // the accepted reference is the first since restart
    logic mark_ok;     // time mark that may open a window
    logic tick_ok;     // tick that may advance the cycle time
  } ttmc_ev_t;

endpackage

// File: rtl/ttmc_mode_ctrl.sv
module ttmc_mode_ctrl
  import ttmc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cfg_exit,
  input  logic     cfg_enter,
  input  logic     ref_ok,
  input  logic     ref_err,
  input  logic     time_mark,
  input  logic     time_tick,
  output ttmc_ev_t ev,
  output logic     running,
  output logic     valid
);

  logic running_q, running_d;
  logic first_q,   first_d;
  logic valid_q,   valid_d;
  logic active;

  // Next state
  always_comb begin
    running_d = running_q;
    first_d   = first_q;
    valid_d   = valid_q;
    if (cfg_enter) begin
      running_d = 1'b0;
      valid_d   = 1'b0;
    end else if (cfg_exit) begin
      running_d = 1'b1;
      first_d   = 1'b1;
      valid_d   = 1'b0;
    end else if (running_q) begin
      if (ref_ok) begin
        first_d = 1'b0;
        valid_d = 1'b1;
      end else if (ref_err) begin
        valid_d = 1'b0;
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      first_q   <= 1'b0;
      valid_q   <= 1'b0;
    end else begin
      running_q <= running_d;
      first_q   <= first_d;
      valid_q   <= valid_d;
    end
  end

  // Event decode
  assign active        = running_q & ~cfg_enter & ~cfg_exit;
  assign ev.restart    = cfg_exit & ~cfg_enter;
  assign ev.ref_accept = active & ref_ok;
  assign ev.first_ref  = first_q;
  assign ev.mark_ok    = active & valid_q & ~ref_ok & time_mark;
  assign ev.tick_ok    = active & valid_q & ~ref_ok & time_tick;

  assign running = running_q;
  assign valid   = valid_q;

  // R11
  enter_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_enter |=> (!valid_q && !running_q));

  // R10
  ref_err_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && ref_err && !ref_ok && !cfg_enter && !cfg_exit) |=> !valid_q);

  // R4
  ref_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev.ref_accept |=> valid_q);

  // R2
  idle_not_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running_q |-> !valid_q);

endmodule

// File: rtl/ttmc_cycle_ctr.sv
module ttmc_cycle_ctr
  import ttmc_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ttmc_ev_t         ev,
  input  logic [CNT_W-1:0] max_cycle,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = ev.restart | (ev.ref_accept & ~ev.first_ref);

  always_comb begin
    cnt_d = cnt_q;
    if (ev.restart)               cnt_d = '0;
    else if (cnt_q >= max_cycle)  cnt_d = '0;
    else                          cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R5
  cycle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.ref_accept && !ev.first_ref && !ev.restart)
      |=> ((cnt_q == '0) || (cnt_q == $past(cnt_q) + 1'b1)));

  // R4
  first_ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.ref_accept && ev.first_ref) |=> $stable(cnt_q));

endmodule

// File: rtl/ttmc_window_ctr.sv
module ttmc_window_ctr
  import ttmc_pkg::*;
#(
  parameter int WIN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ttmc_ev_t         ev,
  input  logic [WIN_W-1:0] max_window,
  output logic [WIN_W-1:0] index
);

  logic [WIN_W-1:0] win_q, win_d;
  logic             at_limit;
  logic             win_en;

  assign at_limit = (win_q >= max_window);
  assign win_en   = ev.restart | ev.ref_accept | (ev.mark_ok & ~at_limit);

  always_comb begin
    win_d = win_q + 1'b1;
    if (ev.restart || ev.ref_accept) win_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      win_q <= '0;
    else if (win_en) win_q <= win_d;
  end

  assign index = win_q;

  // R7
  window_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.mark_ok && at_limit && !ev.restart && !ev.ref_accept) |=> $stable(win_q));

  // R6
  window_ref_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev.ref_accept |=> (win_q == '0));

endmodule

// File: rtl/ttmc_time_ctr.sv
module ttmc_time_ctr
  import ttmc_pkg::*;
#(
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ttmc_ev_t          ev,
  output logic [TIME_W-1:0] ctime
);

  logic [TIME_W-1:0] time_q, time_d;
  logic              time_en;

  assign time_en = ev.restart | ev.ref_accept | ev.tick_ok;

  always_comb begin
    time_d = time_q + 1'b1;
    if (ev.restart || ev.ref_accept) time_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       time_q <= '0;
    else if (time_en) time_q <= time_d;
  end

  assign ctime = time_q;

  // R6
  time_ref_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev.ref_accept |=> (time_q == '0));

  // R8
  time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev.tick_ok && !ev.restart && !ev.ref_accept) |=> $stable(time_q));

endmodule

// File: rtl/ttmc_tracker.sv
module ttmc_tracker
  import ttmc_pkg::*;
#(
  parameter int CNT_W       = 6,
  parameter int WIN_W       = 5,
  parameter int TIME_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_exit,
  input  logic              cfg_enter,
  input  logic              ref_ok,
  input  logic              ref_err,
  input  logic              time_mark,
  input  logic              time_tick,
  input  logic [CNT_W-1:0]  max_cycle,
  input  logic [WIN_W-1:0]  max_window,
  output logic [CNT_W-1:0]  cycle_count,
  output logic [WIN_W-1:0]  window_idx,
  output logic [TIME_W-1:0] cycle_time,
  output logic              time_valid
);

  localparam int SYNC_LAST = SYNC_STAGES - 1;

  logic [SYNC_LAST:0] rst_pipe;
  logic               rst_sync_n;
  ttmc_ev_t           ev;
  logic               running;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_LAST-1:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_LAST];

  ttmc_mode_ctrl u_mode (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_exit  (cfg_exit),
    .cfg_enter (cfg_enter),
    .ref_ok    (ref_ok),
    .ref_err   (ref_err),
    .time_mark (time_mark),
    .time_tick (time_tick),
    .ev        (ev),
    .running   (running),
    .valid     (time_valid)
  );

  ttmc_cycle_ctr #(.CNT_W(CNT_W)) u_cycle (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ev        (ev),
    .max_cycle (max_cycle),
    .count     (cycle_count)
  );

  ttmc_window_ctr #(.WIN_W(WIN_W)) u_window (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ev         (ev),
    .max_window (max_window),
    .index      (window_idx)
  );

  ttmc_time_ctr #(.TIME_W(TIME_W)) u_time (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ev    (ev),
    .ctime (cycle_time)
  );

  // R3
  exit_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_exit && !cfg_enter)
      |=> (cycle_count == '0 && window_idx == '0 && cycle_time == '0 && !time_valid));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!running && !cfg_exit) |=> ($stable(cycle_count) && $stable(window_idx) && $stable(cycle_time)));

endmodule

// File: tb/ttmc_tracker_tb.sv
module ttmc_tracker_tb;

  localparam int CW = 6;
  localparam int WW = 5;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_exit, cfg_enter, ref_ok, ref_err, time_mark, time_tick;
  logic [CW-1:0] max_cycle;
  logic [WW-1:0] max_window;
  logic [CW-1:0] cycle_count;
  logic [WW-1:0] window_idx;
  logic [TW-1:0] cycle_time;
  logic          time_valid;

  int    vectors = 0;
  int    misses  = 0;
  int    cyc     = 0;
  string req     = "R1";

  // behavioural reference state
  int m_run, m_first, m_valid, m_bcc, m_win, m_time;

  always #10 clk = ~clk;

  ttmc_tracker #(.CNT_W(CW), .WIN_W(WW), .TIME_W(TW)) u_dut (
    .clk (clk), .rst_n (rst_n),
    .cfg_exit (cfg_exit), .cfg_enter (cfg_enter),
    .ref_ok (ref_ok), .ref_err (ref_err),
    .time_mark (time_mark), .time_tick (time_tick),
    .max_cycle (max_cycle), .max_window (max_window),
    .cycle_count (cycle_count), .window_idx (window_idx),
    .cycle_time (cycle_time), .time_valid (time_valid)
  );

  // reference model, stepped on every clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_first = 0; m_valid = 0; m_bcc = 0; m_win = 0; m_time = 0;
    end else if (cfg_enter) begin
      m_run = 0; m_valid = 0;
    end else if (cfg_exit) begin
      m_run = 1; m_first = 1; m_valid = 0; m_bcc = 0; m_win = 0; m_time = 0;
    end else if (m_run != 0) begin
      if (ref_ok) begin
        if (m_first != 0) m_first = 0;
        else m_bcc = (m_bcc >= int'(max_cycle)) ? 0 : m_bcc + 1;
        m_win = 0; m_time = 0; m_valid = 1;
      end else begin
        if (m_valid != 0 && time_mark && m_win < int'(max_window)) m_win = m_win + 1;
        if (m_valid != 0 && time_tick) m_time = (m_time + 1) % (1 << TW);
        if (ref_err) m_valid = 0;
      end
    end
  end

  task automatic compare();
    bit bad = 0;
    vectors++;
    if (int'(cycle_count) != m_bcc) begin
      $display("FAIL %s cycle_count act %0d exp %0d", req, cycle_count, m_bcc); bad = 1;
    end
    if (int'(window_idx) != m_win) begin
      $display("FAIL %s window_idx act %0d exp %0d", req, window_idx, m_win); bad = 1;
    end
    if (int'(cycle_time) != m_time) begin
      $display("FAIL %s cycle_time act %0d exp %0d", req, cycle_time, m_time); bad = 1;
    end
    if (int'(time_valid) != m_valid) begin
      $display("FAIL %s time_valid act %0d exp %0d", req, time_valid, m_valid); bad = 1;
    end
    if (bad) misses++;
  endtask

  // drive one cycle of strobes, then compare after the edge
  task automatic step(input bit ex, input bit en, input bit ok, input bit er,
                      input bit mk, input bit tk);
    cfg_exit = ex; cfg_enter = en; ref_ok = ok; ref_err = er;
    time_mark = mk; time_tick = tk;
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  // direct check of one field against a value taken from a requirement
  task automatic expect_val(input string r, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s act %0d exp %0d", r, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      misses++;
      $display("FAIL watchdog act %0d exp <150000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_exit = 0; cfg_enter = 0; ref_ok = 0; ref_err = 0; time_mark = 0; time_tick = 0;
    max_cycle = CW'(3); max_window = WW'(4);
    repeat (3) @(negedge clk);
    req = "R1";
    compare();
    expect_val("R1", "time_valid", int'(time_valid), 0);
    rst_n = 1'b1;
    idle(4);

    // R2: protocol strobes ignored in configuration mode
    req = "R2";
    step(0, 0, 1, 0, 1, 1);
    step(0, 0, 0, 1, 1, 1);
    step(0, 0, 1, 0, 0, 0);
    expect_val("R2", "cycle_count", int'(cycle_count), 0);
    expect_val("R2", "time_valid", int'(time_valid), 0);

    // R3: leave configuration
    req = "R3";
    step(1, 0, 0, 0, 0, 0);

    // R8: marks and ticks before the first reference
    req = "R8";
    step(0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 1, 0);
    expect_val("R8", "window_idx", int'(window_idx), 0);
    expect_val("R8", "cycle_time", int'(cycle_time), 0);

    // R4: first reference
    req = "R4";
    step(0, 0, 1, 0, 0, 0);
    expect_val("R4", "time_valid", int'(time_valid), 1);
    expect_val("R4", "cycle_count", int'(cycle_count), 0);

    // R9 and R7
    req = "R9";
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 1);
    expect_val("R9", "cycle_time", int'(cycle_time), 5);
    req = "R7";
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 1, 0);
    expect_val("R7", "window_idx", int'(window_idx), 4);

    // R6: reference overrides same-cycle mark and tick
    req = "R6";
    step(0, 0, 1, 0, 1, 1);
    expect_val("R6", "window_idx", int'(window_idx), 0);
    expect_val("R6", "cycle_time", int'(cycle_time), 0);
    expect_val("R6", "cycle_count", int'(cycle_count), 1);

    // R5: wrap after max_cycle
    req = "R5";
    step(0, 0, 1, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0);
    expect_val("R5", "cycle_count", int'(cycle_count), 3);
    step(0, 0, 1, 0, 0, 0);
    expect_val("R5", "cycle_count", int'(cycle_count), 0);

    // R9: cycle time wraps modulo 2^TW
    req = "R9";
    for (int i = 0; i < 260; i++) step(0, 0, 0, 0, 0, 1);
    expect_val("R9", "cycle_time", int'(cycle_time), 4);

    // R10: reference error
    req = "R10";
    step(0, 0, 0, 1, 0, 0);
    expect_val("R10", "time_valid", int'(time_valid), 0);
    expect_val("R10", "cycle_time", int'(cycle_time), 4);
    step(0, 0, 0, 0, 1, 1);
    expect_val("R10", "window_idx", int'(window_idx), 0);

    // R3: exit from a non-zero state
    req = "R3";
    step(0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 1, 1);
    step(1, 0, 0, 0, 0, 0);
    expect_val("R3", "window_idx", int'(window_idx), 0);
    expect_val("R3", "cycle_count", int'(cycle_count), 0);
    step(0, 0, 1, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0);
    expect_val("R3", "cycle_count", int'(cycle_count), 1);

    // R11: configuration entry and priority over exit
    req = "R11";
    step(0, 1, 0, 0, 0, 0);
    expect_val("R11", "time_valid", int'(time_valid), 0);
    step(0, 0, 1, 0, 1, 1);
    step(1, 1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0);
    expect_val("R11", "cycle_count", int'(cycle_count), 1);
    expect_val("R11", "time_valid", int'(time_valid), 0);

    // mixed stimulus against the model
    req = "R7";
    max_cycle = CW'(5); max_window = WW'(6);
    step(1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      step(r == 0, r == 1, (r >= 2 && r < 6), (r >= 6 && r < 8),
           $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1);
      if (i == 2000) begin
        max_cycle = CW'(2);
        max_window = WW'(3);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule